// File: doc/BRIEF.md
# Drive Command Register Decoder

This block is the register-level command front end of a removable disk drive controller. A host places an argument in a 32-bit data register and then writes a command word. Bits 23:16 of that word select an operation. Within one clock the block updates its state. A seek latches a target track taken from the upper half of the data register, marks the track as index-locked, records whether the access will read or write, and pulses a start strobe towards an external zone and offset mapper. Clock-query commands overwrite the data register with two BCD bytes from a time-of-day input. A disk inquiry clears the data register.

Every command write raises a single shared mechanism interrupt, whether the opcode is recognised or not. The host clears the interrupt by writing an acknowledge word with bit 24 set. Reads are combinational from the word address. The status word carries the interrupt flag and the live disk-present input. A fixed identification word is also readable. Motor, head and seek timing are not modelled: every command takes effect at the clock edge that accepts it.

Top module: `drv_cmd_ctrl`

## Requirements
- R1: After reset the data register, the track word and the status word read zero (with disk_present low), irq is low, seek_write is low and seek_start is low.
- R2: A write to word offset 0x00 loads the data register, and a read of offset 0x00 returns it.
- R3: A write to the command offset 0x02 takes its opcode from bits 23:16 and ignores all other bits. Opcode 0x01 (seek for read) loads track bits 15:0 from data bits 31:16, sets track word bits 30 and 29 (index lock), and clears seek_write. The track word is read at offset 0x03.
- R4: Opcode 0x02 (seek for write) updates the track word the same way as R3 and sets seek_write.
- R5: seek_start is high for exactly the one cycle after a seek command write, with seek_track holding the new track. It stays low for every other opcode.
- R6: Opcode 0x12 loads the data register with {year mod 100, month, 16'h0000}, both bytes in BCD.
- R7: Opcode 0x13 loads {day, hour, 16'h0000} and opcode 0x14 loads {minute, second, 16'h0000}.
- R8: Opcode 0x1B (disk inquiry) clears the data register to zero.
- R9: Every command write sets status bit 25 and drives irq high. A write to offset 0x04 with bit 24 set clears both. The same write with bit 24 clear leaves them set.
- R10: Any other opcode, for example 0x05 or 0x7F, leaves the data register, the track word and seek_write unchanged.
- R11: Status, read at offset 0x02, bit 24 equals disk_present at the time of the read.
- R12: Offset 0x10 reads 0x00030000.
- R13: Reads of unassigned offsets, including 0x01, 0x04 and 0x3F, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (6) | Word offset for reads and writes |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for addr |
| disk_present | input | 1 | A disk is inserted |
| tod_year | input | 8 | BCD year modulo 100 |
| tod_month | input | 8 | BCD month |
| tod_day | input | 8 | BCD day of month |
| tod_hour | input | 8 | BCD hour |
| tod_min | input | 8 | BCD minute |
| tod_sec | input | 8 | BCD second |
| irq | output | 1 | Mechanism interrupt |
| seek_start | output | 1 | One-cycle strobe after a seek |
| seek_track | output | TRACK_W (16) | Latched target track |
| seek_write | output | 1 | Direction of the last seek, 1 for write |

## Verification
The bench sends command words that carry set bits outside the opcode field. A decoder that looked at more than bits 23:16 would then mistake a clock query for an unknown command and leave the data register untouched. Unknown opcodes are followed by reads of data, track and direction. This catches a default branch that clears or reloads state, and an unknown command that fails to raise the interrupt. The bench also checks that seek_start lasts exactly one cycle and appears only for the two seek opcodes, and that an acknowledge without bit 24 leaves the interrupt set. The disk-present bit is read on both sides of a toggle, which exposes a status word that was latched instead of live.

// File: rtl/drv_cmd_pkg.sv
package drv_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_SEEK_RD,
    CMD_SEEK_WR,
    CMD_CLK_YM,
    CMD_CLK_DH,
    CMD_CLK_MS,
    CMD_INQ,
    CMD_OTHER
  } cmd_kind_e;

  localparam logic [7:0] OP_SEEK_RD = 8'h01;
  localparam logic [7:0] OP_SEEK_WR = 8'h02;
  localparam logic [7:0] OP_CLK_YM  = 8'h12;
  localparam logic [7:0] OP_CLK_DH  = 8'h13;
  localparam logic [7:0] OP_CLK_MS  = 8'h14;
  localparam logic [7:0] OP_INQ     = 8'h1B;

  // word offsets
  localparam int OFS_DATA  = 'h00;
  localparam int OFS_CMD   = 'h02;
  localparam int OFS_TRACK = 'h03;
  localparam int OFS_ACK   = 'h04;
  localparam int OFS_ID    = 'h10;

  // bit positions
  localparam int OPC_LSB       = 16;
  localparam int STAT_DISK_BIT = 24;
  localparam int STAT_MECH_BIT = 25;
  localparam int ACK_MECH_BIT  = 24;
  localparam int LOCK_HI_BIT   = 30;
  localparam int LOCK_LO_BIT   = 29;

endpackage

// File: rtl/drv_cmd_decode.sv
module drv_cmd_decode
  import drv_cmd_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [7:0] opcode,
  input  logic [7:0] tod_year,
  input  logic [7:0] tod_month,
  input  logic [7:0] tod_day,
  input  logic [7:0] tod_hour,
  input  logic [7:0] tod_min,
  input  logic [7:0] tod_sec,
  output cmd_kind_e  kind,
  output logic [7:0] bcd_hi,
  output logic [7:0] bcd_lo
);

  always_comb begin
    kind = CMD_NONE;
    if (cmd_wr) begin
      unique case (opcode)
        OP_SEEK_RD: kind = CMD_SEEK_RD;
        OP_SEEK_WR: kind = CMD_SEEK_WR;
        OP_CLK_YM:  kind = CMD_CLK_YM;
        OP_CLK_DH:  kind = CMD_CLK_DH;
        OP_CLK_MS:  kind = CMD_CLK_MS;
        OP_INQ:     kind = CMD_INQ;
        default:    kind = CMD_OTHER;
      endcase
    end
  end

  // pick the BCD pair for the clock queries
  always_comb begin
    bcd_hi = tod_year;
    bcd_lo = tod_month;
    unique case (kind)
      CMD_CLK_DH: begin bcd_hi = tod_day; bcd_lo = tod_hour; end
      CMD_CLK_MS: begin bcd_hi = tod_min; bcd_lo = tod_sec;  end
      default:    begin bcd_hi = tod_year; bcd_lo = tod_month; end
    endcase
  end

endmodule

// File: rtl/drv_cmd_regs.sv
module drv_cmd_regs
  import drv_cmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TRACK_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  cmd_kind_e          kind,
  input  logic [7:0]         bcd_hi,
  input  logic [7:0]         bcd_lo,
  input  logic               ack_clr,
  output logic [DATA_W-1:0]  data_q,
  output logic [TRACK_W-1:0] track_q,
  output logic               lock_q,
  output logic               dir_wr_q,
  output logic               mint_q,
  output logic               pulse_q
);

  localparam int PAD_W = DATA_W - 16;

  logic [DATA_W-1:0]  data_d;
  logic [TRACK_W-1:0] track_d;
  logic               lock_d, dir_wr_d, mint_d;
  logic               is_seek, is_cmd, state_en;

  assign is_seek  = (kind == CMD_SEEK_RD) || (kind == CMD_SEEK_WR);
  assign is_cmd   = (kind != CMD_NONE);
  assign state_en = data_wr | is_cmd | ack_clr;

  always_comb begin
    data_d   = data_q;
    track_d  = track_q;
    lock_d   = lock_q;
    dir_wr_d = dir_wr_q;
    mint_d   = mint_q;
    if (data_wr) data_d = wdata;
    unique case (kind)
      CMD_SEEK_RD, CMD_SEEK_WR: begin
        track_d  = data_q[DATA_W-1 -: TRACK_W];
        lock_d   = 1'b1;
        dir_wr_d = (kind == CMD_SEEK_WR);
      end
      CMD_CLK_YM, CMD_CLK_DH, CMD_CLK_MS:
        data_d = {bcd_hi, bcd_lo, {PAD_W{1'b0}}};
      CMD_INQ:
        data_d = '0;
      default: ;
    endcase
    if (is_cmd)       mint_d = 1'b1;
    else if (ack_clr) mint_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      track_q  <= '0;
      lock_q   <= 1'b0;
      dir_wr_q <= 1'b0;
      mint_q   <= 1'b0;
    end else if (state_en) begin
      data_q   <= data_d;
      track_q  <= track_d;
      lock_q   <= lock_d;
      dir_wr_q <= dir_wr_d;
      mint_q   <= mint_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= is_seek;
  end

endmodule

// File: rtl/drv_cmd_rdmux.sv
module drv_cmd_rdmux
  import drv_cmd_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 6,
  parameter int              TRACK_W  = 16,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0003_0000
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data_q,
  input  logic [TRACK_W-1:0] track_q,
  input  logic               lock_q,
  input  logic               mint_q,
  input  logic               disk_present,
  output logic [DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] status_w, track_w;

  always_comb begin
    status_w = '0;
    status_w[STAT_DISK_BIT] = disk_present;
    status_w[STAT_MECH_BIT] = mint_q;
    track_w = '0;
    track_w[TRACK_W-1:0] = track_q;
    track_w[LOCK_HI_BIT] = lock_q;
    track_w[LOCK_LO_BIT] = lock_q;
  end

  always_comb begin
    rdata = '0;
    if      (addr == ADDR_W'(OFS_DATA))  rdata = data_q;
    else if (addr == ADDR_W'(OFS_CMD))   rdata = status_w;
    else if (addr == ADDR_W'(OFS_TRACK)) rdata = track_w;
    else if (addr == ADDR_W'(OFS_ID))    rdata = ID_VALUE;
  end

endmodule

// File: rtl/drv_cmd_ctrl.sv
module drv_cmd_ctrl
  import drv_cmd_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 6,
  parameter int                TRACK_W  = 16,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0003_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               disk_present,
  input  logic [7:0]         tod_year,
  input  logic [7:0]         tod_month,
  input  logic [7:0]         tod_day,
  input  logic [7:0]         tod_hour,
  input  logic [7:0]         tod_min,
  input  logic [7:0]         tod_sec,
  output logic               irq,
  output logic               seek_start,
  output logic [TRACK_W-1:0] seek_track,
  output logic               seek_write
);

  logic              data_wr, cmd_wr, ack_clr;
  cmd_kind_e         kind;
  logic [7:0]        bcd_hi, bcd_lo;
  logic [DATA_W-1:0] data_q;
  logic [TRACK_W-1:0] track_q;
  logic              lock_q, dir_wr_q, mint_q, pulse_q;

  assign data_wr = wr_en && (addr == ADDR_W'(OFS_DATA));
  assign cmd_wr  = wr_en && (addr == ADDR_W'(OFS_CMD));
  assign ack_clr = wr_en && (addr == ADDR_W'(OFS_ACK)) && wdata[ACK_MECH_BIT];

  drv_cmd_decode u_dec (
    .cmd_wr    (cmd_wr),
    .opcode    (wdata[OPC_LSB +: 8]),
    .tod_year  (tod_year),
    .tod_month (tod_month),
    .tod_day   (tod_day),
    .tod_hour  (tod_hour),
    .tod_min   (tod_min),
    .tod_sec   (tod_sec),
    .kind      (kind),
    .bcd_hi    (bcd_hi),
    .bcd_lo    (bcd_lo)
  );

  drv_cmd_regs #(.DATA_W(DATA_W), .TRACK_W(TRACK_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (data_wr),
    .wdata    (wdata),
    .kind     (kind),
    .bcd_hi   (bcd_hi),
    .bcd_lo   (bcd_lo),
    .ack_clr  (ack_clr),
    .data_q   (data_q),
    .track_q  (track_q),
    .lock_q   (lock_q),
    .dir_wr_q (dir_wr_q),
    .mint_q   (mint_q),
    .pulse_q  (pulse_q)
  );

  drv_cmd_rdmux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TRACK_W(TRACK_W), .ID_VALUE(ID_VALUE)
  ) u_rd (
    .addr         (addr),
    .data_q       (data_q),
    .track_q      (track_q),
    .lock_q       (lock_q),
    .mint_q       (mint_q),
    .disk_present (disk_present),
    .rdata        (rdata)
  );

  assign irq        = mint_q;
  assign seek_start = pulse_q;
  assign seek_track = track_q;
  assign seek_write = dir_wr_q;

endmodule

// File: rtl/drv_cmd_ctrl_chk.sv
module drv_cmd_ctrl_chk
  import drv_cmd_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 6,
  parameter int                TRACK_W  = 16,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0003_0000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic               disk_present,
  input logic               irq,
  input logic               seek_start,
  input logic [TRACK_W-1:0] seek_track,
  input logic               seek_write,
  input logic [DATA_W-1:0]  data_q
);

  logic cmd_w, seek_cmd, ack_w;
  assign cmd_w    = wr_en && (addr == ADDR_W'(OFS_CMD));
  assign seek_cmd = cmd_w && ((wdata[OPC_LSB +: 8] == OP_SEEK_RD) ||
                              (wdata[OPC_LSB +: 8] == OP_SEEK_WR));
  assign ack_w    = wr_en && (addr == ADDR_W'(OFS_ACK)) && wdata[ACK_MECH_BIT];

  p_cmd_raises_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w |=> irq);

  p_ack_clears_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> !irq);

  p_start_only_after_seek_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seek_start |-> $past(seek_cmd));

  p_seek_track_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seek_start |-> (seek_track == $past(data_q[DATA_W-1 -: TRACK_W])));

  p_dir_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !seek_cmd |=> $stable(seek_write));

  p_status_disk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(OFS_CMD)) |-> (rdata[STAT_DISK_BIT] == disk_present));

  p_id_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(OFS_ID)) |-> (rdata == ID_VALUE));

endmodule

bind drv_cmd_ctrl drv_cmd_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TRACK_W(TRACK_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .disk_present (disk_present),
  .irq          (irq),
  .seek_start   (seek_start),
  .seek_track   (seek_track),
  .seek_write   (seek_write),
  .data_q       (data_q)
);

// File: tb/drv_cmd_ctrl_tb.sv
module drv_cmd_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        disk_present = 1'b0;
  logic [7:0]  tod_year = 8'h24, tod_month = 8'h07, tod_day = 8'h15;
  logic [7:0]  tod_hour = 8'h23, tod_min = 8'h59, tod_sec = 8'h08;
  logic        irq, seek_start, seek_write;
  logic [15:0] seek_track;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  drv_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .disk_present(disk_present),
    .tod_year(tod_year), .tod_month(tod_month), .tod_day(tod_day),
    .tod_hour(tod_hour), .tod_min(tod_min), .tod_sec(tod_sec),
    .irq(irq), .seek_start(seek_start), .seek_track(seek_track),
    .seek_write(seek_write)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // returns on the falling edge after the accepting rising edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h00, v); check("R1 data", v, 32'h0);
    rd(6'h03, v); check("R1 track", v, 32'h0);
    rd(6'h02, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 seek_write", {31'b0, seek_write}, 32'h0);
    check("R1 seek_start", {31'b0, seek_start}, 32'h0);
  endtask

  task automatic t_data_rw;
    logic [31:0] v;
    wr(6'h00, 32'hA5A5_1234);
    rd(6'h00, v); check("R2 readback", v, 32'hA5A5_1234);
    wr(6'h00, 32'h0000_0001);
    rd(6'h00, v); check("R2 second write", v, 32'h0000_0001);
  endtask

  task automatic t_seek_read;
    logic [31:0] v;
    wr(6'h00, 32'h0123_ABCD);
    wr(6'h02, 32'h0001_0000);
    check("R5 start after seek read", {31'b0, seek_start}, 32'h1);
    check("R5 seek_track", {16'b0, seek_track}, 32'h0123);
    check("R3 seek_write low", {31'b0, seek_write}, 32'h0);
    rd(6'h03, v); check("R3 track word", v, 32'h6000_0123);
    @(negedge clk);
    check("R5 start one cycle", {31'b0, seek_start}, 32'h0);
    check("R9 irq after seek", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_seek_write;
    logic [31:0] v;
    wr(6'h00, 32'h0456_0000);
    wr(6'h02, 32'hFF02_00FF);  // extra bits outside the opcode field
    check("R5 start after seek write", {31'b0, seek_start}, 32'h1);
    check("R4 seek_write high", {31'b0, seek_write}, 32'h1);
    rd(6'h03, v); check("R4 track word", v, 32'h6000_0456);
    @(negedge clk);
    check("R5 start drops", {31'b0, seek_start}, 32'h0);
  endtask

  task automatic t_clock;
    logic [31:0] v;
    wr(6'h02, 32'h0012_0000);
    rd(6'h00, v); check("R6 year month", v, 32'h2407_0000);
    check("R5 no start on clock op", {31'b0, seek_start}, 32'h0);
    wr(6'h02, 32'hA513_5A5A);  // R3: only bits 23:16 matter
    rd(6'h00, v); check("R7 day hour", v, 32'h1523_0000);
    tod_min = 8'h07; tod_sec = 8'h42;
    wr(6'h02, 32'h0014_0000);
    rd(6'h00, v); check("R7 minute second", v, 32'h0742_0000);
  endtask

  task automatic t_inquiry;
    logic [31:0] v;
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h02, 32'h001B_0000);
    rd(6'h00, v); check("R8 inquiry clears", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(6'h04, 32'h0100_0000);
    check("R9 ack clears irq", {31'b0, irq}, 32'h0);
    rd(6'h02, v); check("R9 status bit25 cleared", {31'b0, v[25]}, 32'h0);
    wr(6'h02, 32'h0099_0000);   // unknown opcode still interrupts
    check("R9 unknown op irq", {31'b0, irq}, 32'h1);
    rd(6'h02, v); check("R9 status bit25 set", {31'b0, v[25]}, 32'h1);
    wr(6'h04, 32'hFEFF_FFFF);   // bit 24 clear
    check("R9 ack without bit24", {31'b0, irq}, 32'h1);
    wr(6'h04, 32'h0100_0000);
    check("R9 ack again", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_other;
    logic [31:0] v;
    wr(6'h00, 32'hDEAD_BEEF);
    wr(6'h02, 32'h0005_0000);
    check("R10 no start", {31'b0, seek_start}, 32'h0);
    wr(6'h02, 32'h007F_0000);
    rd(6'h00, v); check("R10 data kept", v, 32'hDEAD_BEEF);
    rd(6'h03, v); check("R10 track kept", v, 32'h6000_0456);
    check("R10 direction kept", {31'b0, seek_write}, 32'h1);
    check("R9 irq on other op", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_disk;
    logic [31:0] v;
    disk_present = 1'b1;
    rd(6'h02, v); check("R11 disk present", {31'b0, v[24]}, 32'h1);
    disk_present = 1'b0;
    rd(6'h02, v); check("R11 disk absent", {31'b0, v[24]}, 32'h0);
  endtask

  task automatic t_id_undef;
    logic [31:0] v;
    rd(6'h10, v); check("R12 id", v, 32'h0003_0000);
    rd(6'h01, v); check("R13 offset 1", v, 32'h0);
    rd(6'h04, v); check("R13 offset 4", v, 32'h0);
    rd(6'h3F, v); check("R13 offset 3f", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_data_rw;
    t_seek_read;
    t_seek_write;
    t_clock;
    t_inquiry;
    t_irq;
    t_other;
    t_disk;
    t_id_undef;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule